// File: doc/BRIEF.md
# PWM Current Chopper with Decay Control

This block runs the current regulation loop of one full bridge that drives a single motor winding. A free-running counter divides the system clock into fixed-length PWM cycles. At the start of every cycle the bridge is switched on in the commanded polarity. Current then builds until an external comparator reports that the chopping threshold has been reached. The block ignores that comparator for a blanking interval after turn-on, so the blanking interval is also the shortest possible on-time. Once a trip is accepted, the block holds the bridge in a decay state until the cycle ends.

Three decay behaviours are available:
- **Slow:** both low-side switches recirculate the current.
- **Fast:** the bridge is reversed, and every switch opens once a near-zero-current flag appears, so no reverse current flows.
- **Mixed:** fast decay that changes to slow decay at three quarters of the period, but only while the setpoint is falling. While the setpoint is rising, mixed mode decays slowly.

A zero setpoint skips the drive phase and holds slow decay for the whole cycle. A disable input turns every switch off and restarts the cycle counter.

Each half-bridge has its own dead-time stage. It turns off at once, but turns on only after both switches of that half-bridge have been off for the dead interval. All four gate enables come straight from flops.

Top module: `pwm_chopper`

## Requirements
- R1: While `rst` or `disable_i` is high, all four gate enables are 0 from the next clock edge. After `disable_i` falls, the cycle counter restarts at zero, so a new cycle (and its drive phase) begins at once.
- R2: The cycle length is CLK_HZ/PWM_HZ clocks. Each cycle starts with the drive state. With polarity 1, half-bridge 0 is high and half-bridge 1 is low. With polarity 0, half-bridge 0 is low and half-bridge 1 is high.
- R3: `trip_i` has no effect while the in-cycle count is below the blanking count, which is BLANK_NS rounded up to whole clocks. A trip that is only present during blanking leaves the bridge driving until the cycle ends.
- R4: An accepted trip ends the drive state. The decay state then persists to the end of the cycle even if `trip_i` falls again.
- R5: Slow decay (select 2'b00) turns on both low-side switches and no high-side switch.
- R6: Fast decay (select 2'b10 or 2'b11) applies the reverse of the drive state.
- R7: During fast decay, `near_zero_i` switches all four gates off until the cycle ends.
- R8: Mixed decay (select 2'b01) with `falling_i` = 1 applies fast decay while the count is below 3/4 of the period. From the decision at 3/4 of the period it applies slow decay, and this takes priority over the near-zero cut-off. A trip accepted at or after that point goes straight to slow decay.
- R9: Mixed decay with `falling_i` = 0 behaves as slow decay.
- R10: Select code 2'b11 behaves exactly like 2'b10.
- R11: A switch turns on only after both switches of its half-bridge have been off for DEAD_NS rounded up to whole clocks (at least one clock). The high-side and low-side enables of one half-bridge are never on together. A half-bridge that keeps its state across a phase change never goes off.
- R12: If `zero_set_i` is 1 at cycle start, the whole cycle is slow decay and no drive occurs.
- R13: `polarity_i`, `decay_sel_i`, `falling_i` and `zero_set_i` are sampled only at the cycle-start count. Changes at other counts do not alter the gates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| disable_i | input | 1 | Forces all gates off; releasing it restarts the cycle |
| trip_i | input | 1 | Current comparator, 1 = threshold reached |
| near_zero_i | input | 1 | 1 = winding current close to zero |
| polarity_i | input | 1 | 1 = positive current (half-bridge 0 high, half-bridge 1 low) |
| decay_sel_i | input | 2 | 00 slow, 01 mixed (mid level), 1x fast |
| falling_i | input | 1 | 1 = setpoint magnitude decreasing |
| zero_set_i | input | 1 | 1 = setpoint magnitude is zero |
| hs_en_o | output | 2 | High-side gate enables, bit i = half-bridge i |
| ls_en_o | output | 2 | Low-side gate enables, bit i = half-bridge i |

## Verification
The bench predicts the in-cycle count from the release of `disable_i`. Any decision taken on count c reaches the gates two clocks later, during count c+2. A switch that must first go off and then turn on reappears a further dead interval (DEAD clocks) after that. Trip and near-zero inputs are driven as functions of the predicted count, in both level and single-pulse form. The gate enables are compared on the falling edge of every clock over two full cycles of each configuration. The expected value for each clock comes from a closed-form phase schedule, followed by a per-half-bridge dead-time rule.

// File: rtl/pwm_chop_pkg.sv
package pwm_chop_pkg;

  // State requested for one half-bridge
  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_HI  = 2'd1,
    LEG_LO  = 2'd2
  } leg_e;

  // Regulation phase within a PWM cycle
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_DRIVE = 3'd1,
    PH_FAST  = 3'd2,
    PH_COAST = 3'd3,
    PH_SLOW  = 3'd4
  } phase_e;

  // Decay select codes; bit 1 set means fast decay
  localparam logic [1:0] SEL_SLOW  = 2'b00;
  localparam logic [1:0] SEL_MIXED = 2'b01;

endpackage

// File: rtl/pwm_chop_timer.sv
module pwm_chop_timer #(
  parameter int PERIOD_CYC = 5000,
  parameter int BLANK_CYC  = 938,
  parameter int MIX_CYC    = 3750,
  parameter int CW         = $clog2(PERIOD_CYC)
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  output logic start_o,
  output logic blank_done_o,
  output logic past_mix_o
);

  localparam logic [CW-1:0] LAST_L  = CW'(PERIOD_CYC - 1);
  localparam logic [CW-1:0] BLANK_L = CW'(BLANK_CYC);
  localparam logic [CW-1:0] MIX_L   = CW'(MIX_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || hold_i) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST_L) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign start_o      = (cnt_q == '0);
  assign blank_done_o = (cnt_q >= BLANK_L);
  assign past_mix_o   = (cnt_q >= MIX_L);

  // R2: the count wraps after the last position of the period
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst || hold_i)
    (cnt_q == LAST_L) |=> (cnt_q == '0));

  // R2: the count never leaves the period
  p_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST_L);

endmodule

// File: rtl/pwm_chop_phase.sv
module pwm_chop_phase
  import pwm_chop_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         hold_i,
  input  logic         start_i,
  input  logic         blank_done_i,
  input  logic         past_mix_i,
  input  logic         trip_i,
  input  logic         near_zero_i,
  input  logic         polarity_i,
  input  logic [1:0]   decay_sel_i,
  input  logic         falling_i,
  input  logic         zero_set_i,
  output leg_e [1:0]   leg_req_o
);

  phase_e     ph_q;
  phase_e     decay_entry;
  logic       pol_q;
  logic [1:0] sel_q;
  logic       fall_q;
  logic       mix_fall;

  assign mix_fall = (sel_q == SEL_MIXED) && fall_q;

  always_comb begin
    if (sel_q[1]) begin
      decay_entry = PH_FAST;
    end else if (mix_fall) begin
      decay_entry = past_mix_i ? PH_SLOW : PH_FAST;
    end else begin
      decay_entry = PH_SLOW;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || hold_i) begin
      ph_q   <= PH_IDLE;
      pol_q  <= 1'b0;
      sel_q  <= SEL_SLOW;
      fall_q <= 1'b0;
    end else if (start_i) begin
      pol_q  <= polarity_i;
      sel_q  <= decay_sel_i;
      fall_q <= falling_i;
      ph_q   <= zero_set_i ? PH_SLOW : PH_DRIVE;
    end else begin
      case (ph_q)
        PH_DRIVE: if (blank_done_i && trip_i) ph_q <= decay_entry;
        PH_FAST: begin
          if (mix_fall && past_mix_i) ph_q <= PH_SLOW;
          else if (near_zero_i)      ph_q <= PH_COAST;
        end
        PH_COAST: if (mix_fall && past_mix_i) ph_q <= PH_SLOW;
        default: ph_q <= ph_q;
      endcase
    end
  end

  always_comb begin
    leg_req_o[0] = LEG_OFF;
    leg_req_o[1] = LEG_OFF;
    case (ph_q)
      PH_DRIVE: begin
        leg_req_o[0] = pol_q ? LEG_HI : LEG_LO;
        leg_req_o[1] = pol_q ? LEG_LO : LEG_HI;
      end
      PH_FAST: begin
        leg_req_o[0] = pol_q ? LEG_LO : LEG_HI;
        leg_req_o[1] = pol_q ? LEG_HI : LEG_LO;
      end
      PH_SLOW: begin
        leg_req_o[0] = LEG_LO;
        leg_req_o[1] = LEG_LO;
      end
      default: begin
        leg_req_o[0] = LEG_OFF;
        leg_req_o[1] = LEG_OFF;
      end
    endcase
  end

  // R3: a trip inside the blanking window does not end the drive
  p_blank_r3: assert property (@(posedge clk) disable iff (rst || hold_i)
    (ph_q == PH_DRIVE && !blank_done_i && !start_i) |=> (ph_q == PH_DRIVE));

  // R4: once decaying, drive does not return before the next cycle start
  p_decay_hold_r4: assert property (@(posedge clk) disable iff (rst || hold_i)
    (ph_q inside {PH_FAST, PH_COAST, PH_SLOW} && !start_i) |=> (ph_q != PH_DRIVE));

  // R8: mixed decay on a falling setpoint is slow after the three-quarter point
  p_mixed_r8: assert property (@(posedge clk) disable iff (rst || hold_i)
    (ph_q inside {PH_FAST, PH_COAST} && mix_fall && past_mix_i && !start_i)
      |=> (ph_q == PH_SLOW));

  // R12: a zero setpoint opens the cycle in slow decay
  p_zero_r12: assert property (@(posedge clk) disable iff (rst || hold_i)
    (start_i && zero_set_i) |=> (ph_q == PH_SLOW));

endmodule

// File: rtl/pwm_chop_deadleg.sv
module pwm_chop_deadleg
  import pwm_chop_pkg::*;
#(
  parameter int DEAD_CYC = 125,
  parameter int DW       = $clog2(DEAD_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  input  leg_e req_i,
  output logic hs_o,
  output logic ls_o
);

  localparam logic [DW-1:0] SAT_L = DW'(DEAD_CYC - 1);

  logic [DW-1:0] off_q;
  leg_e          cur;

  always_comb begin
    if (hs_o)      cur = LEG_HI;
    else if (ls_o) cur = LEG_LO;
    else           cur = LEG_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst || hold_i) begin
      hs_o  <= 1'b0;
      ls_o  <= 1'b0;
      off_q <= '0;
    end else if (cur != LEG_OFF) begin
      if (req_i != cur) begin
        hs_o  <= 1'b0;
        ls_o  <= 1'b0;
        off_q <= '0;
      end
    end else if (req_i != LEG_OFF && off_q >= SAT_L) begin
      hs_o <= (req_i == LEG_HI);
      ls_o <= (req_i == LEG_LO);
    end else if (off_q < SAT_L) begin
      off_q <= off_q + 1'b1;
    end
  end

  // R11: no shoot-through within the half-bridge
  p_no_shoot_r11: assert property (@(posedge clk) disable iff (rst)
    !(hs_o && ls_o));

  // R11: a switch never turns on straight from its complement
  p_gap_hi_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_o) |-> !$past(ls_o));
  p_gap_lo_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_o) |-> !$past(hs_o));

endmodule

// File: rtl/pwm_chopper.sv
module pwm_chopper
  import pwm_chop_pkg::*;
#(
  parameter int CLK_HZ   = 250_000_000,
  parameter int PWM_HZ   = 50_000,
  parameter int BLANK_NS = 3750,
  parameter int DEAD_NS  = 500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       disable_i,
  input  logic       trip_i,
  input  logic       near_zero_i,
  input  logic       polarity_i,
  input  logic [1:0] decay_sel_i,
  input  logic       falling_i,
  input  logic       zero_set_i,
  output logic [1:0] hs_en_o,
  output logic [1:0] ls_en_o
);

  localparam int CLK_KHZ    = CLK_HZ / 1000;
  localparam int PERIOD_CYC = CLK_HZ / PWM_HZ;
  localparam int BLANK_CYC  = (CLK_KHZ * BLANK_NS + 999_999) / 1_000_000;
  localparam int MIX_CYC    = (PERIOD_CYC * 3) / 4;
  localparam int DEAD_RAW   = (CLK_KHZ * DEAD_NS + 999_999) / 1_000_000;
  localparam int DEAD_CYC   = (DEAD_RAW < 1) ? 1 : DEAD_RAW;
  localparam int CW         = $clog2(PERIOD_CYC);

  logic       start;
  logic       blank_done;
  logic       past_mix;
  leg_e [1:0] leg_req;

  pwm_chop_timer #(
    .PERIOD_CYC(PERIOD_CYC),
    .BLANK_CYC (BLANK_CYC),
    .MIX_CYC   (MIX_CYC),
    .CW        (CW)
  ) u_timer (
    .clk         (clk),
    .rst         (rst),
    .hold_i      (disable_i),
    .start_o     (start),
    .blank_done_o(blank_done),
    .past_mix_o  (past_mix)
  );

  pwm_chop_phase u_phase (
    .clk         (clk),
    .rst         (rst),
    .hold_i      (disable_i),
    .start_i     (start),
    .blank_done_i(blank_done),
    .past_mix_i  (past_mix),
    .trip_i      (trip_i),
    .near_zero_i (near_zero_i),
    .polarity_i  (polarity_i),
    .decay_sel_i (decay_sel_i),
    .falling_i   (falling_i),
    .zero_set_i  (zero_set_i),
    .leg_req_o   (leg_req)
  );

  for (genvar g = 0; g < 2; g++) begin : g_leg
    pwm_chop_deadleg #(
      .DEAD_CYC(DEAD_CYC)
    ) u_leg (
      .clk   (clk),
      .rst   (rst),
      .hold_i(disable_i),
      .req_i (leg_req[g]),
      .hs_o  (hs_en_o[g]),
      .ls_o  (ls_en_o[g])
    );
  end

  // R1: disable clears every gate at the next edge
  p_disable_r1: assert property (@(posedge clk) disable iff (rst)
    disable_i |=> (hs_en_o == 2'b00 && ls_en_o == 2'b00));

  // R6: both high sides are never on together
  p_no_dual_high_r6: assert property (@(posedge clk) disable iff (rst)
    hs_en_o != 2'b11);

endmodule

// File: tb/pwm_chopper_tb.sv
`timescale 1ns/1ps
module pwm_chopper_tb;

  // Small configuration: 40-clock period, 8-clock blank, 2-clock dead time
  localparam int TB_CLK_HZ   = 1_000_000;
  localparam int TB_PWM_HZ   = 25_000;
  localparam int TB_BLANK_NS = 8000;
  localparam int TB_DEAD_NS  = 2000;
  localparam int P    = TB_CLK_HZ / TB_PWM_HZ;
  localparam int BL   = 8;
  localparam int MIX  = (P * 3) / 4;
  localparam int DEAD = 2;
  localparam int NEVER = 1000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       disable_i = 1'b0;
  logic       trip_i = 1'b0;
  logic       near_zero_i = 1'b0;
  logic       polarity_i = 1'b0;
  logic [1:0] decay_sel_i = 2'b00;
  logic       falling_i = 1'b0;
  logic       zero_set_i = 1'b0;
  logic [1:0] hs_en_o;
  logic [1:0] ls_en_o;

  pwm_chopper #(
    .CLK_HZ  (TB_CLK_HZ),
    .PWM_HZ  (TB_PWM_HZ),
    .BLANK_NS(TB_BLANK_NS),
    .DEAD_NS (TB_DEAD_NS)
  ) u_dut (
    .clk        (clk),
    .rst        (rst),
    .disable_i  (disable_i),
    .trip_i     (trip_i),
    .near_zero_i(near_zero_i),
    .polarity_i (polarity_i),
    .decay_sel_i(decay_sel_i),
    .falling_i  (falling_i),
    .zero_set_i (zero_set_i),
    .hs_en_o    (hs_en_o),
    .ls_en_o    (ls_en_o)
  );

  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // scenario
  int s_mode, s_pol, s_fall, s_zero, s_t, s_z, s_pulse, s_noisy;
  bit first;
  // expected per half-bridge: 0 off, 1 high, 2 low
  int exp_leg [2];
  int exp_off [2];
  bit gap;

  // phases: 0 idle, 1 drive, 2 fast, 3 coast, 4 slow
  function automatic int trip_pos();
    if (s_pulse != 0) return (s_t >= BL) ? s_t : NEVER;
    return (s_t > BL) ? s_t : BL;
  endfunction

  function automatic int ph_at(int pin);
    int p, te, cz;
    p = pin;
    if (p == 0 && first) return 0;
    if (p == 0) p = P;
    if (s_zero != 0) return 4;
    te = trip_pos();
    if (p <= te) return 1;
    if (s_mode == 0) return 4;
    if (s_mode == 1) begin
      if (s_fall == 0) return 4;
      if (te >= MIX) return 4;
      if (p >= MIX + 1) return 4;
    end
    cz = ((s_z > te + 1) ? s_z : te + 1) + 1;
    return (p >= cz) ? 3 : 2;
  endfunction

  function automatic int req_of(int ph, int leg);
    int hi_leg;
    hi_leg = (s_pol != 0) ? 0 : 1;
    case (ph)
      1: return (leg == hi_leg) ? 1 : 2;
      2: return (leg == hi_leg) ? 2 : 1;
      4: return 2;
      default: return 0;
    endcase
  endfunction

  task automatic step_model(int ph);
    gap = 1'b0;
    for (int i = 0; i < 2; i++) begin
      int r;
      r = req_of(ph, i);
      if (exp_leg[i] != 0) begin
        if (r != exp_leg[i]) begin
          exp_leg[i] = 0;
          exp_off[i] = 0;
        end
      end else if (r != 0 && exp_off[i] >= DEAD - 1) begin
        exp_leg[i] = r;
      end else if (exp_off[i] < DEAD - 1) begin
        exp_off[i] = exp_off[i] + 1;
      end
      if (r != 0 && exp_leg[i] == 0) gap = 1'b1;
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 2; i++) begin
      exp_leg[i] = 0;
      exp_off[i] = 0;
    end
  endtask

  task automatic drive_inputs(int p);
    trip_i      = (s_pulse != 0) ? (p == s_t) : (p >= s_t);
    near_zero_i = (p >= s_z);
    if (s_noisy != 0 && p != 0) begin
      polarity_i  = (s_pol == 0);
      decay_sel_i = 2'(s_mode) ^ 2'b11;
      falling_i   = (s_fall == 0);
      zero_set_i  = (s_zero == 0);
    end else begin
      polarity_i  = (s_pol != 0);
      decay_sel_i = 2'(s_mode);
      falling_i   = (s_fall != 0);
      zero_set_i  = (s_zero != 0);
    end
  endtask

  function automatic string tag_of(int ph, int p);
    if (s_noisy != 0) return "R13";
    if (s_zero != 0)  return "R12";
    if (gap)          return "R11";
    if (s_mode == 3)  return "R10";
    if (ph == 0)      return "R1";
    if (ph == 1)      return (p <= BL) ? "R3" : "R2";
    if (s_pulse != 0) return "R4";
    if (s_mode == 1)  return (s_fall != 0) ? "R8" : "R9";
    if (ph == 4)      return "R5";
    if (ph == 2)      return "R6";
    return "R7";
  endfunction

  task automatic check_out(string tag);
    logic [1:0] ehs, els;
    for (int i = 0; i < 2; i++) begin
      ehs[i] = (exp_leg[i] == 1);
      els[i] = (exp_leg[i] == 2);
    end
    checks++;
    if (hs_en_o !== ehs || ls_en_o !== els) begin
      errors++;
      $display("FAIL %s: mode=%0d pol=%0d fall=%0d t=%0d z=%0d pulse=%0d hs=%b ls=%b expected hs=%b ls=%b",
               tag, s_mode, s_pol, s_fall, s_t, s_z, s_pulse, hs_en_o, ls_en_o, ehs, els);
    end
  endtask

  task automatic run_scen();
    int p;
    disable_i = 1'b1;
    drive_inputs(0);
    repeat (3) @(negedge clk);
    model_clear();
    check_out("R1");  // R1: disabled bridge is fully off
    disable_i = 1'b0;
    first = 1'b1;
    p = 0;
    for (int k = 0; k < 2 * P; k++) begin
      int ph;
      drive_inputs(p);
      ph = ph_at(p);
      step_model(ph);
      @(negedge clk);
      check_out(tag_of(ph, p));
      p = (p + 1) % P;
      if (p == 0) first = 1'b0;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    int tv [5];
    int zv [2];
    tv = '{0, 5, 15, 33, 99};
    zv = '{20, 99};
    s_mode = 0; s_pol = 0; s_fall = 0; s_zero = 0;
    s_t = 99; s_z = 99; s_pulse = 0; s_noisy = 0;
    model_clear();
    repeat (4) @(negedge clk);
    check_out("R1");  // R1: reset state, all gates off
    rst = 1'b0;
    // main sweep
    for (int m = 0; m < 4; m++)
      for (int po = 0; po < 2; po++)
        for (int f = 0; f < 2; f++)
          for (int ti = 0; ti < 5; ti++)
            for (int zi = 0; zi < 2; zi++)
              for (int pu = 0; pu < 2; pu++)
                for (int nz = 0; nz < 2; nz++) begin
                  s_mode = m; s_pol = po; s_fall = f; s_zero = 0;
                  s_t = tv[ti]; s_z = zv[zi]; s_pulse = pu; s_noisy = nz;
                  run_scen();
                end
    // R12: zero setpoint runs
    for (int m = 0; m < 4; m++)
      for (int po = 0; po < 2; po++)
        for (int nz = 0; nz < 2; nz++) begin
          s_mode = m; s_pol = po; s_fall = 1; s_zero = 1;
          s_t = 15; s_z = 20; s_pulse = 0; s_noisy = nz;
          run_scen();
        end
    finish_run();
  end

  initial begin
    repeat (150_000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    finish_run();
  end

endmodule